// File: doc/BRIEF.md
# Machine Control and Status Register File

This block holds the control and status registers of a small 64-bit processor core. A 12-bit register number selects an entry on a read port that answers in the same cycle, and on a write port with its own enable that commits at the next clock edge. The floating-point status is kept in one 8-bit register. Three register numbers view it: the whole byte, only the exception flags, and only the rounding mode. Writes through a partial view merge into the byte and leave the other field as it was.

Two 64-bit counters are kept in the block. One counts clock cycles and one counts retired instructions. Separate register numbers read the low and the high 32-bit half of each. The hart identifier, the vendor, architecture and implementation identifiers and a fixed ISA descriptor are constants. The block also holds 24 plain 64-bit trap registers, 8 for each of the user, supervisor and machine levels.

Any register number with its top two bits set is read-only. A write there is dropped and reported on a one-cycle flag. A read of a number that maps to nothing returns zero and raises a flag in the same cycle.

Top module: `mcsr_file`

## Requirements
- R1: A read of register 0x001 returns bits 4:0 of the floating-point status byte, zero-extended.
- R2: A read of register 0x002 returns bits 7:5 of the status byte, zero-extended.
- R3: A write to 0x001 loads wr_data[4:0] into status bits 4:0 and leaves bits 7:5 unchanged.
- R4: A write to 0x002 loads wr_data[2:0] into status bits 7:5 and leaves bits 4:0 unchanged.
- R5: A write to 0x003 stores wr_data[7:0]. A read of 0x003 returns the status byte with bits 63:8 zero.
- R6: A write whose address has bits 11:10 equal to 2'b11 changes no state. wr_illegal is high in the cycle after such a write, and low after any other cycle.
- R7: Register 0x301 reads 0x8000000000101129 from reset, and writes to it have no effect. Registers 0xF11, 0xF12 and 0xF13 read zero.
- R8: The hart identifier, register 0xF14, reads zero.
- R9: 0xC00 and 0xC02 read bits 31:0 of the cycle and retired-instruction counters. 0xC80 and 0xC82 read bits 63:32 of the same counters.
- R10: Both counters are zero while rst is high. The cycle counter then rises by one on every clock. The retired counter rises by one on each clock where retire is high.
- R11: The trap registers live at addresses with bits 11:10 = 0, bits 9:8 in {0,1,3} and bits 7:0 in {0x00,0x04,0x05,0x40,0x41,0x42,0x43,0x44}. Each reads back the last value written and clears to zero on reset.
- R12: A read of an address that maps to nothing returns zero with rd_illegal high. A read of any implemented register leaves rd_illegal low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr | input | 12 | Register number for the read port |
| rd_data | output | 64 | Read value, same cycle |
| rd_illegal | output | 1 | Read address maps to nothing |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Register number for the write port |
| wr_data | input | 64 | Write value |
| wr_illegal | output | 1 | Previous cycle held a dropped read-only write |
| retire | input | 1 | One instruction retired this cycle |

## Verification
The assertions check on every cycle the merge of partial floating-point writes into the status byte and the clean upper bits of a full-status read. They also check the read-only write flag in both directions, the counter step rules, and the zero data that comes with an illegal read. The descriptor reset value, the exact bit positions returned by each alias, and the isolation of a read-only address from the trap register that shares its low bits can only be shown by the bench's scenarios. The same holds for the read-back of every trap level.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

    localparam int ADDR_W   = 12;
    localparam int FLAG_W   = 5;
    localparam int RMODE_W  = 3;
    localparam int FPS_W    = FLAG_W + RMODE_W;
    localparam int N_SLOTS  = 8;
    localparam int N_LEVELS = 3;
    localparam int N_STORE  = N_SLOTS * N_LEVELS;
    localparam int IDX_W    = $clog2(N_STORE);

    typedef logic [ADDR_W-1:0] csr_addr_t;

    localparam csr_addr_t A_FLAGS  = 12'h001;
    localparam csr_addr_t A_RMODE  = 12'h002;
    localparam csr_addr_t A_FPALL  = 12'h003;
    localparam csr_addr_t A_CYC_LO = 12'hC00;
    localparam csr_addr_t A_RET_LO = 12'hC02;
    localparam csr_addr_t A_CYC_HI = 12'hC80;
    localparam csr_addr_t A_RET_HI = 12'hC82;
    localparam csr_addr_t A_VEND   = 12'hF11;
    localparam csr_addr_t A_ARCH   = 12'hF12;
    localparam csr_addr_t A_IMPL   = 12'hF13;
    localparam csr_addr_t A_HART   = 12'hF14;
    localparam csr_addr_t A_DESC   = 12'h301;

    localparam logic [63:0] DESC_VALUE = 64'h8000_0000_0010_1129;

    typedef enum logic [1:0] {
        FPV_NONE,
        FPV_FLAGS,
        FPV_RMODE,
        FPV_ALL
    } fp_view_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } store_sel_t;

    function automatic logic read_only_addr(csr_addr_t a);
        return a[11:10] == 2'b11;
    endfunction

    function automatic store_sel_t store_decode(csr_addr_t a);
        store_sel_t s;
        int         lvl;
        int         slot;
        lvl  = -1;
        slot = -1;
        case (a[9:8])
            2'd0:    lvl = 0;
            2'd1:    lvl = 1;
            2'd3:    lvl = 2;
            default: lvl = -1;
        endcase
        case (a[7:0])
            8'h00:   slot = 0;
            8'h04:   slot = 1;
            8'h05:   slot = 2;
            8'h40:   slot = 3;
            8'h41:   slot = 4;
            8'h42:   slot = 5;
            8'h43:   slot = 6;
            8'h44:   slot = 7;
            default: slot = -1;
        endcase
        s.hit = (a[11:10] == 2'b00) && (lvl >= 0) && (slot >= 0);
        s.idx = s.hit ? IDX_W'(lvl * N_SLOTS + slot) : '0;
        return s;
    endfunction

    function automatic fp_view_e fp_view_of(csr_addr_t a);
        case (a)
            A_FLAGS: return FPV_FLAGS;
            A_RMODE: return FPV_RMODE;
            A_FPALL: return FPV_ALL;
            default: return FPV_NONE;
        endcase
    endfunction

endpackage

// File: rtl/mcsr_fpstat.sv
module mcsr_fpstat
    import mcsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  fp_view_e         wr_view,
    input  logic [FPS_W-1:0] wr_byte,
    output logic [FPS_W-1:0] fps_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            fps_q <= '0;
        end else begin
            case (wr_view)
                FPV_FLAGS: fps_q <= {fps_q[FPS_W-1:FLAG_W], wr_byte[FLAG_W-1:0]};
                FPV_RMODE: fps_q <= {wr_byte[RMODE_W-1:0], fps_q[FLAG_W-1:0]};
                FPV_ALL:   fps_q <= wr_byte;
                default:   fps_q <= fps_q;
            endcase
        end
    end

endmodule

// File: rtl/mcsr_counters.sv
module mcsr_counters #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             retire,
    output logic [CNT_W-1:0] cyc_q,
    output logic [CNT_W-1:0] ret_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= '0;
            ret_q <= '0;
        end else begin
            cyc_q <= cyc_q + CNT_W'(1);
            if (retire) begin
                ret_q <= ret_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/mcsr_store.sv
module mcsr_store
    import mcsr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]  wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [XLEN-1:0]  rd_val
);

    logic [XLEN-1:0] regs [N_STORE];

    for (genvar g = 0; g < N_STORE; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                regs[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < N_STORE; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_val = regs[i];
            end
        end
    end

endmodule

// File: rtl/mcsr_file.sv
module mcsr_file
    import mcsr_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int CNT_W = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [11:0]     rd_addr,
    output logic [XLEN-1:0] rd_data,
    output logic            rd_illegal,
    input  logic            wr_en,
    input  logic [11:0]     wr_addr,
    input  logic [XLEN-1:0] wr_data,
    output logic            wr_illegal,
    input  logic            retire
);

    localparam int HALF = CNT_W / 2;

    logic             wr_ok;
    store_sel_t       wsel;
    store_sel_t       rsel;
    fp_view_e         wview;
    logic [FPS_W-1:0] fps_q;
    logic [CNT_W-1:0] cyc_q;
    logic [CNT_W-1:0] ret_q;
    logic [XLEN-1:0]  store_val;
    logic             wr_illegal_q;

    assign wr_ok = wr_en && !read_only_addr(wr_addr);
    assign wsel  = store_decode(wr_addr);
    assign rsel  = store_decode(rd_addr);
    assign wview = wr_ok ? fp_view_of(wr_addr) : FPV_NONE;

    mcsr_fpstat u_fps (
        .clk     (clk),
        .rst     (rst),
        .wr_view (wview),
        .wr_byte (wr_data[FPS_W-1:0]),
        .fps_q   (fps_q)
    );

    mcsr_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .retire (retire),
        .cyc_q  (cyc_q),
        .ret_q  (ret_q)
    );

    mcsr_store #(.XLEN(XLEN)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_ok && wsel.hit),
        .wr_idx  (wsel.idx),
        .wr_data (wr_data),
        .rd_idx  (rsel.idx),
        .rd_val  (store_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_illegal_q <= 1'b0;
        end else begin
            wr_illegal_q <= wr_en && read_only_addr(wr_addr);
        end
    end

    assign wr_illegal = wr_illegal_q;

    always_comb begin
        rd_data    = '0;
        rd_illegal = 1'b0;
        if (rsel.hit) begin
            rd_data = store_val;
        end else begin
            case (rd_addr)
                A_FLAGS:  rd_data = XLEN'(fps_q[FLAG_W-1:0]);
                A_RMODE:  rd_data = XLEN'(fps_q[FPS_W-1:FLAG_W]);
                A_FPALL:  rd_data = XLEN'(fps_q);
                A_CYC_LO: rd_data = XLEN'(cyc_q[HALF-1:0]);
                A_CYC_HI: rd_data = XLEN'(cyc_q[CNT_W-1:HALF]);
                A_RET_LO: rd_data = XLEN'(ret_q[HALF-1:0]);
                A_RET_HI: rd_data = XLEN'(ret_q[CNT_W-1:HALF]);
                A_DESC:   rd_data = XLEN'(DESC_VALUE);
                A_VEND, A_ARCH, A_IMPL, A_HART: rd_data = '0;
                default:  rd_illegal = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/mcsr_file_chk.sv
module mcsr_file_chk
    import mcsr_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic [11:0]      rd_addr,
    input logic [XLEN-1:0]  rd_data,
    input logic             rd_illegal,
    input logic             wr_en,
    input logic [11:0]      wr_addr,
    input logic             wr_illegal,
    input logic             retire,
    input logic [FPS_W-1:0] fps_q,
    input logic [CNT_W-1:0] cyc_q,
    input logic [CNT_W-1:0] ret_q
);

    assert_flags_keep_rmode_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_FLAGS) |=> fps_q[FPS_W-1:FLAG_W] == $past(fps_q[FPS_W-1:FLAG_W]));

    assert_rmode_keep_flags_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_RMODE) |=> fps_q[FLAG_W-1:0] == $past(fps_q[FLAG_W-1:0]));

    assert_fpall_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == A_FPALL) |-> rd_data[XLEN-1:FPS_W] == '0);

    assert_ro_flag_set_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr[11:10] == 2'b11) |=> wr_illegal);

    assert_ro_flag_clear_R6: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr[11:10] == 2'b11) |=> !wr_illegal);

    assert_ro_keeps_fps_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr[11:10] == 2'b11) |=> $stable(fps_q));

    assert_cycle_step_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> cyc_q == $past(cyc_q) + CNT_W'(1));

    assert_retire_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !retire |=> $stable(ret_q));

    assert_retire_step_R10: assert property (@(posedge clk) disable iff (rst)
        retire |=> ret_q == $past(ret_q) + CNT_W'(1));

    assert_illegal_read_zero_R12: assert property (@(posedge clk) disable iff (rst)
        rd_illegal |-> rd_data == '0);

endmodule

bind mcsr_file mcsr_file_chk #(.XLEN(XLEN), .CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .rd_illegal (rd_illegal),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_illegal (wr_illegal),
    .retire     (retire),
    .fps_q      (fps_q),
    .cyc_q      (cyc_q),
    .ret_q      (ret_q)
);

// File: tb/mcsr_file_tb.sv
`timescale 1ns/1ps
module mcsr_file_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] rd_addr = '0;
    logic [63:0] rd_data;
    logic        rd_illegal;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic        wr_illegal;
    logic        retire = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    mcsr_file dut_i (
        .clk        (clk),
        .rst        (rst),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .rd_illegal (rd_illegal),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_illegal (wr_illegal),
        .retire     (retire)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%016h expected 0x%016h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] d, output logic ill);
        rd_addr = a;
        #0.5;
        d   = rd_data;
        ill = rd_illegal;
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [63:0] d; logic ill;
        rd(12'hC00, d, ill); check("R10 cycle at reset release", d, 64'd0);
        rd(12'hC02, d, ill); check("R10 retired at reset release", d, 64'd0);
        rd(12'h003, d, ill); check("R5 status at reset", d, 64'd0);
        rd(12'h341, d, ill); check("R11 trap reg at reset", d, 64'd0);
        check("R6 wr_illegal at reset", {63'd0, wr_illegal}, 64'd0);
    endtask

    task automatic t_fp_alias;
        logic [63:0] d; logic ill;
        wr(12'h003, 64'hFFFF_FFFF_FFFF_FF5A);
        rd(12'h003, d, ill); check("R5 full status keeps low byte", d, 64'h5A);
        rd(12'h001, d, ill); check("R1 flags view", d, 64'h1A);
        rd(12'h002, d, ill); check("R2 rounding view", d, 64'h2);
        wr(12'h001, 64'hFFFF_FFFF_FFFF_FFE5);
        rd(12'h003, d, ill); check("R3 flags write merge", d, 64'h45);
        wr(12'h002, 64'h0000_0000_0000_00FE);
        rd(12'h003, d, ill); check("R4 rounding write merge", d, 64'hC5);
        rd(12'h002, d, ill); check("R2 rounding view after write", d, 64'h6);
        rd(12'h001, d, ill); check("R1 flags view after write", d, 64'h5);
        check("R12 implemented read not illegal", {63'd0, ill}, 64'd0);
    endtask

    task automatic t_ro_write;
        logic [63:0] d; logic ill;
        wr(12'h040, 64'h1111_2222_3333_4444);
        #0.5 check("R6 flag low after plain write", {63'd0, wr_illegal}, 64'd0);
        wr(12'hC40, 64'hDEAD_BEEF_0000_0001);
        #0.5 check("R6 flag high after read-only write", {63'd0, wr_illegal}, 64'd1);
        rd(12'h040, d, ill); check("R6 aliasing trap reg untouched", d, 64'h1111_2222_3333_4444);
        @(negedge clk);
        #0.5 check("R6 flag is one cycle", {63'd0, wr_illegal}, 64'd0);
        wr(12'hF14, 64'hFF);
        rd(12'hF14, d, ill); check("R8 hart id after write", d, 64'd0);
        check("R8 hart id implemented", {63'd0, ill}, 64'd0);
        wr(12'hF03, 64'h77);
        rd(12'h003, d, ill); check("R6 status untouched by 0xF03", d, 64'hC5);
    endtask

    task automatic t_ids;
        logic [63:0] d; logic ill;
        rd(12'h301, d, ill); check("R7 descriptor", d, 64'h8000_0000_0010_1129);
        wr(12'h301, 64'd0);
        rd(12'h301, d, ill); check("R7 descriptor after write", d, 64'h8000_0000_0010_1129);
        rd(12'hF11, d, ill); check("R7 vendor id", d, 64'd0);
        rd(12'hF12, d, ill); check("R7 arch id", d, 64'd0);
        rd(12'hF13, d, ill); check("R7 impl id", {d[62:0], ill}, 64'd0);
    endtask

    task automatic t_counters;
        logic [63:0] c0, c1, r0, r1, d; logic ill;
        @(negedge clk);
        rd(12'hC00, c0, ill);
        repeat (10) @(negedge clk);
        rd(12'hC00, c1, ill);
        check("R10 cycle steps once per clock", c1 - c0, 64'd10);
        rd(12'hC80, d, ill); check("R9 cycle high half", d, 64'd0);
        rd(12'hC02, r0, ill);
        retire = 1'b1;
        repeat (4) @(negedge clk);
        retire = 1'b0;
        repeat (3) @(negedge clk);
        rd(12'hC02, r1, ill);
        check("R10 retired counts strobes", r1 - r0, 64'd4);
        rd(12'hC82, d, ill); check("R9 retired high half", d, 64'd0);
        check("R9 retired nonzero low half", {63'd0, r1 != 0}, 64'd1);
    endtask

    task automatic t_storage;
        logic [63:0] d; logic ill;
        logic [11:0] addrs [6] = '{12'h005, 12'h104, 12'h144, 12'h300, 12'h343, 12'h000};
        for (int i = 0; i < 6; i++) begin
            wr(addrs[i], 64'hA500_0000_0000_0000 | 64'(i * 3 + 1));
        end
        for (int i = 0; i < 6; i++) begin
            rd(addrs[i], d, ill);
            check("R11 trap reg readback", d, 64'hA500_0000_0000_0000 | 64'(i * 3 + 1));
        end
    endtask

    task automatic t_unimpl;
        logic [63:0] d; logic ill;
        rd(12'h200, d, ill); check("R12 unmapped level data", d, 64'd0);
        check("R12 unmapped level flag", {63'd0, ill}, 64'd1);
        rd(12'h306, d, ill); check("R12 unmapped slot flag", {63'd0, ill}, 64'd1);
        rd(12'hC01, d, ill); check("R12 unmapped ro flag", {63'd0, ill}, 64'd1);
        rd(12'h004, d, ill); check("R12 mapped flag low", {63'd0, ill}, 64'd0);
    endtask

    initial begin
        #(200000 * 5);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fp_alias();
        t_ro_write();
        t_ids();
        t_counters();
        t_storage();
        t_unimpl();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule